// File: doc/BRIEF.md
# Frame-Sequential Stereo Video Output

This block turns two per-eye frame stores (one holding the left camera image, one the right) into one display raster. The two views take turns on successive output frames. Each eye is shown at the camera's 30 frames per second, and the display refreshes at 60. A registered shutter-glasses control line tells the viewer's glasses which eye to open. It changes state on the same clock on which vertical sync begins, so the glasses are settled before the next picture starts.

The block produces the whole output timing: horizontal and vertical counters, active-low sync pulses, a data-enable and blanking. The default geometry is a 640x480 picture in an 800x525 raster at a 25 MHz pixel clock. The frame stores are read through a shared linear address and a per-eye read enable. Each store is a plain synchronous memory with one cycle of read latency. The address leads the visible pixel by one clock so the returned word lands in the active window.

The output is a paced raster and takes no back-pressure: no ready exists on either side. The stores must return data one clock after an enabled read, and the display must accept a pixel on every clock.

Top module: `stereo_fs_out`

## Requirements
- R1: While reset is low, `de` is 0, `hsync_n` and `vsync_n` are 1, `glasses_left` is 1 and the colour outputs are 0. The first clock edge after release presents line 0, column 0 of the left image.
- R2: One line lasts H_ACT+H_FP+H_SW+H_BP clocks and one frame lasts V_ACT+V_FP+V_SW+V_BP lines. `de` is high exactly for columns below H_ACT on lines below V_ACT.
- R3: `hsync_n` is low for H_SW clocks starting at column H_ACT+H_FP. `vsync_n` is low for lines V_ACT+V_FP through V_ACT+V_FP+V_SW-1. Neither sync is low while `de` is high.
- R4: Whenever `de` is 0, `red`, `green` and `blue` are all 0.
- R5: The shown eye alternates every frame, starting with left after reset. `glasses_left` (1 means left eye open) changes only on the clock where `vsync_n` falls, and it changes on every such clock.
- R6: During active video the colour outputs carry the word read from the store of the eye that `glasses_left` indicates. Bits 23:16 are red, 15:8 are green and 7:0 are blue. The word is read at the linear address line*H_ACT+column.
- R7: The read for a pixel is issued one clock before it is shown. Only the selected eye's read enable is high, no enable is high outside the active area, and `rd_addr` stays below H_ACT*V_ACT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr | output | ADDR_W | Linear read address shared by both stores |
| left_rd_en | output | 1 | Read enable, left-eye store |
| right_rd_en | output | 1 | Read enable, right-eye store |
| left_rdata | input | 24 | Left store read data, one cycle after enable |
| right_rdata | input | 24 | Right store read data, one cycle after enable |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Active video |
| red | output | 8 | Red channel |
| green | output | 8 | Green channel |
| blue | output | 8 | Blue channel |
| glasses_left | output | 1 | Shutter control: 1 opens the left eye, 0 the right |

## Verification
The store contents are a salted function of eye and address, with a fresh random salt after each reset. A wrong address, a swapped eye or a one-cycle misalignment therefore gives a visibly different colour word. One directed run crosses two frame boundaries, which shows that the eye alternates and that the glasses flip exactly where vertical sync falls. Randomly placed resets of random length land mid-line and mid-frame, and they separate a correct return to the origin with the left eye from a design that keeps stale counter or eye state.

// File: rtl/stereo_fs_pkg.sv
package stereo_fs_pkg;
  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  localparam int PIX_W = $bits(rgb_t);
endpackage

// File: rtl/fs_raster_timer.sv
module fs_raster_timer #(
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SW   = 96,
  parameter int H_BP   = 48,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SW   = 2,
  parameter int V_BP   = 33,
  parameter int ADDR_W = $clog2(H_ACT * V_ACT)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              active,
  output logic              hsync_on,
  output logic              vsync_on,
  output logic              vs_start,
  output logic [ADDR_W-1:0] pix_addr
);
  localparam int H_TOT   = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOT   = V_ACT + V_FP + V_SW + V_BP;
  localparam int HW      = $clog2(H_TOT);
  localparam int VW      = $clog2(V_TOT);
  localparam int PIX_TOT = H_ACT * V_ACT;

  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [HW-1:0] H_VIS  = HW'(H_ACT);
  localparam logic [HW-1:0] HS_BEG = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_ACT + H_FP + H_SW);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [VW-1:0] V_VIS  = VW'(V_ACT);
  localparam logic [VW-1:0] VS_BEG = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_ACT + V_FP + V_SW);
  localparam logic [VW-1:0] VS_PRE = VW'(V_ACT + V_FP - 1);

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          line_end;
  logic          frame_end;

  assign line_end  = (h_cnt == H_LAST);
  assign frame_end = line_end && (v_cnt == V_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (line_end) begin
      h_cnt <= '0;
      v_cnt <= frame_end ? '0 : v_cnt + 1'b1;
    end else begin
      h_cnt <= h_cnt + 1'b1;
    end
  end

  // Running pixel index replaces a line*width multiply.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pix_addr <= '0;
    else if (frame_end) pix_addr <= '0;
    else if (active)    pix_addr <= pix_addr + 1'b1;
  end

  assign active   = (h_cnt < H_VIS) && (v_cnt < V_VIS);
  assign hsync_on = (h_cnt >= HS_BEG) && (h_cnt < HS_END);
  assign vsync_on = (v_cnt >= VS_BEG) && (v_cnt < VS_END);
  assign vs_start = line_end && (v_cnt == VS_PRE);

  // R2: column counter stays inside the line and wraps to zero
  a_r2_h_bound: assert property (@(posedge clk) disable iff (!rst_n)
    h_cnt <= H_LAST);
  a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (h_cnt == '0));
  // R7: every issued address lies inside the frame store
  a_r7_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (int'(pix_addr) < PIX_TOT));
  a_r7_addr_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt == '0 && v_cnt == '0) |-> (pix_addr == '0));
endmodule

// File: rtl/fs_eye_toggle.sv
module fs_eye_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_start,
  output logic eye_left
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        eye_left <= 1'b1;
    else if (vs_start) eye_left <= ~eye_left;
  end

  // R5: eye flips only on entry to vertical sync
  a_r5_flip: assert property (@(posedge clk) disable iff (!rst_n)
    vs_start |=> (eye_left != $past(eye_left)));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_start |=> $stable(eye_left));
endmodule

// File: rtl/stereo_fs_out.sv
module stereo_fs_out
  import stereo_fs_pkg::*;
#(
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SW   = 96,
  parameter int H_BP   = 48,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SW   = 2,
  parameter int V_BP   = 33,
  parameter int ADDR_W = $clog2(H_ACT * V_ACT)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              left_rd_en,
  output logic              right_rd_en,
  input  logic [PIX_W-1:0]  left_rdata,
  input  logic [PIX_W-1:0]  right_rdata,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              de,
  output logic [7:0]        red,
  output logic [7:0]        green,
  output logic [7:0]        blue,
  output logic              glasses_left
);
  logic active, hsync_on, vsync_on, vs_start, eye_left;
  rgb_t pix_out;

  fs_raster_timer #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
    .ADDR_W(ADDR_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .hsync_on (hsync_on),
    .vsync_on (vsync_on),
    .vs_start (vs_start),
    .pix_addr (rd_addr)
  );

  fs_eye_toggle u_eye (
    .clk      (clk),
    .rst_n    (rst_n),
    .vs_start (vs_start),
    .eye_left (eye_left)
  );

  // Read is issued now; data and timing appear together one clock later.
  assign left_rd_en  = active &&  eye_left;
  assign right_rd_en = active && !eye_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de           <= 1'b0;
      hsync_n      <= 1'b1;
      vsync_n      <= 1'b1;
      glasses_left <= 1'b1;
    end else begin
      de           <= active;
      hsync_n      <= ~hsync_on;
      vsync_n      <= ~vsync_on;
      glasses_left <= eye_left;
    end
  end

  always_comb begin
    pix_out = '0;
    if (de) pix_out = rgb_t'(glasses_left ? left_rdata : right_rdata);
  end

  assign red   = pix_out.r;
  assign green = pix_out.g;
  assign blue  = pix_out.b;

  // R7: at most one store is read, and only in the active area
  a_r7_one_store: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_rd_en && right_rd_en));
  // R3: sync pulses never overlap visible video
  a_r3_sync_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_n || !vsync_n) |-> !de);
  // R5: glasses flip exactly where vertical sync falls
  a_r5_glasses_on_vs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> (glasses_left != $past(glasses_left)));
  a_r5_glasses_only_vs: assert property (@(posedge clk) disable iff (!rst_n)
    (glasses_left != $past(glasses_left)) |-> $fell(vsync_n));
endmodule

// File: tb/stereo_fs_out_bench.sv
module stereo_fs_out_bench;
  localparam int HA = 8, HFP = 2, HSW = 3, HBP = 2;
  localparam int VA = 4, VFP = 1, VSW = 2, VBP = 1;
  localparam int HT = HA + HFP + HSW + HBP;
  localparam int VT = VA + VFP + VSW + VBP;
  localparam int FT = HT * VT;
  localparam int AW = $clog2(HA * VA);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] rd_addr;
  logic left_rd_en, right_rd_en;
  logic [23:0] lq, rq;
  logic hsync_n, vsync_n, de, glasses_left;
  logic [7:0] red, green, blue;
  logic [23:0] salt;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stereo_fs_out #(
    .H_ACT(HA), .H_FP(HFP), .H_SW(HSW), .H_BP(HBP),
    .V_ACT(VA), .V_FP(VFP), .V_SW(VSW), .V_BP(VBP), .ADDR_W(AW)
  ) u_stereo_fs_out (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr),
    .left_rd_en(left_rd_en), .right_rd_en(right_rd_en),
    .left_rdata(lq), .right_rdata(rq),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
    .red(red), .green(green), .blue(blue), .glasses_left(glasses_left)
  );

  function automatic logic [23:0] pix(bit eye, int addr, logic [23:0] s);
    logic [7:0] a;
    a = 8'(addr);
    return {a ^ s[7:0], (eye ? 8'hC3 : 8'h3C) ^ s[15:8], a + s[23:16]};
  endfunction

  // Eye shown at raster position p counted from reset release.
  function automatic bit eye_at(int p);
    int q;
    q = (VA + VFP) * HT;
    if (p < q) return 1'b1;
    return (((p - q) / FT + 1) % 2) == 0;
  endfunction

  // Synchronous stores with one cycle of latency.
  always_ff @(posedge clk) begin
    if (left_rd_en)  lq <= pix(1'b1, int'(rd_addr), salt);
    if (right_rd_en) rq <= pix(1'b0, int'(rd_addr), salt);
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_reset();
    check(de == 1'b0, "R1 de in reset", int'(de), 0);
    check(hsync_n && vsync_n, "R1 syncs in reset", int'({hsync_n, vsync_n}), 3);
    check(glasses_left == 1'b1, "R1 glasses in reset", int'(glasses_left), 1);
    check({red, green, blue} == 24'h0, "R1 rgb in reset", int'({red, green, blue}), 0);
  endtask

  // Read port at raster position p (counters now at p).
  task automatic check_read(int p);
    int h, v;
    bit act, eye;
    h = (p % HT); v = (p / HT) % VT;
    act = (h < HA) && (v < VA);
    eye = eye_at(p);
    check(left_rd_en == (act && eye), "R7 left_rd_en", int'(left_rd_en), int'(act && eye));
    check(right_rd_en == (act && !eye), "R7 right_rd_en", int'(right_rd_en), int'(act && !eye));
    if (act) check(int'(rd_addr) == v * HA + h, "R7 rd_addr", int'(rd_addr), v * HA + h);
  endtask

  // Outputs after edge k show raster position k-1.
  task automatic check_out(int k);
    int p, h, v;
    bit act, eye, hs, vs;
    logic [23:0] exp;
    p = k - 1;
    h = p % HT; v = (p / HT) % VT;
    act = (h < HA) && (v < VA);
    hs  = !((h >= HA + HFP) && (h < HA + HFP + HSW));
    vs  = !((v >= VA + VFP) && (v < VA + VFP + VSW));
    eye = eye_at(p);
    exp = act ? pix(eye, v * HA + h, salt) : 24'h0;
    check(de == act, "R2 de", int'(de), int'(act));
    check(hsync_n == hs, "R3 hsync_n", int'(hsync_n), int'(hs));
    check(vsync_n == vs, "R3 vsync_n", int'(vsync_n), int'(vs));
    check(glasses_left == eye, "R5 glasses_left", int'(glasses_left), int'(eye));
    if (k == 1)
      check({red, green, blue} == pix(1'b1, 0, salt), "R1 first pixel",
            int'({red, green, blue}), int'(pix(1'b1, 0, salt)));
    else if (act)
      check({red, green, blue} == exp, "R6 pixel", int'({red, green, blue}), int'(exp));
    else
      check({red, green, blue} == 24'h0, "R4 blank rgb", int'({red, green, blue}), 0);
  endtask

  task automatic run_segment(int cycles, int rst_cycles);
    rst_n = 1'b0;
    for (int i = 0; i < rst_cycles; i++) begin
      @(negedge clk);
      check_reset();
    end
    salt = 24'($urandom());
    rst_n = 1'b1;
    check_read(0);
    for (int k = 1; k <= cycles; k++) begin
      @(negedge clk);
      check_out(k);
      check_read(k);
    end
    @(negedge clk);
  endtask

  initial begin
    salt = 24'($urandom(32'd2024));
    // directed: two full frame changes from reset
    run_segment(2 * FT + 10, 3);
    // directed: reset lands just after vertical sync starts
    run_segment((VA + VFP) * HT + 3, 1);
    // directed: four frames to see the eye return to left twice
    run_segment(4 * FT + 1, 2);
    // random resets mid-line and mid-frame
    for (int s = 0; s < 6; s++)
      run_segment($urandom_range(3 * FT, 5), $urandom_range(4, 1));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule